// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Through Cache

This block sits between a processor load/store port and a slower backing memory. It keeps four one-word blocks, arranged as two sets of two ways. A request address is split into a byte offset, a set index and a tag. The two ways of the indexed set are compared against the tag in the same cycle.

A read that matches a valid way returns its word on the cycle after the request is accepted. A read that misses fetches the word from memory. The word is then returned to the requester and also placed in the indexed set. Every write goes out to memory at once. The same write also updates the cache: it overwrites the matching way, or it claims a way when no way matches. Each set keeps one replacement bit. An empty way is always filled before a valid way is evicted.

The request side is a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no memory transaction is pending, so the requester must hold its request stable until it is taken. Read data comes back as a one-cycle `rsp_valid` pulse with no back-pressure, so the requester must always be able to take it. The memory request channel is also valid/ready. The cache holds address, data and direction stable until `mem_req_ready` is seen. Memory returns read data as a one-cycle `mem_rsp_valid` pulse.

Top module: `wtc_cache_2way`

## Requirements
- R1: The address bits are used as follows. Bits [1:0] are a byte offset that neither hit detection nor returned data depends on. Bit [2] selects the set. Bits [5:3] form the tag. Every memory request carries the block address with bits [1:0] forced to zero.
- R2: A read that hits raises `rsp_valid` with the stored word on the cycle after acceptance, and issues no memory request.
- R3: A read that misses issues one memory read for its block. It returns `mem_rsp_rdata` on `rsp_valid` one cycle after `mem_rsp_valid`, and stores that word in the indexed set.
- R4: A block is placed only in the set named by its index bit, in either way. Two blocks of one set and two blocks of the other set can all be resident together.
- R5: A fill goes to way 0 if that way is invalid, else to way 1 if invalid, else to the way named by the set's replacement bit. Any hit or fill marks the accessed way most recently used, so the other way becomes the next victim.
- R6: Every accepted write produces exactly one memory write, with the same block address and data, on the cycle after acceptance.
- R7: A write that hits replaces the matching way's word, and a following read of that block hits and returns the new word.
- R8: A write that misses places the block into the victim way chosen as in R5, and a following read of that block hits.
- R9: `req_ready` is low while a memory request is pending or a read fill is awaited, and high otherwise. A pending memory request holds its address and direction until `mem_req_ready` is seen.
- R10: Reset clears all valid bits and replacement bits. After reset `req_ready` is high, `rsp_valid` and `mem_req_valid` are low, and the first read misses.
- R11: At most one way of the indexed set matches a tag, so a write hit never leaves a second copy of a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache can take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Load data valid (one cycle) |
| rsp_rdata | output | DATA_W | Load data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = memory write, 0 = memory read |
| mem_req_addr | output | ADDR_W | Word-aligned memory address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_rsp_valid | input | 1 | Memory read data valid (one cycle) |
| mem_rsp_rdata | input | DATA_W | Memory read data |

## Verification
The bench builds the block with its default parameters: a 6-bit address, 32-bit words, a 2-bit offset and two sets. With only four blocks, a third distinct tag in one set forces an eviction after two fills. This means every replacement-bit state, invalid-first filling and write-miss allocation can be reached in a few dozen accesses. The memory model stalls `mem_req_ready` on every third cycle and answers reads two cycles late. This exercises the held memory request and the stalled request port.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ
  } ctl_state_e;
endpackage

// File: rtl/wtc_tag_match.sv
module wtc_tag_match
  import wtc_pkg::*;
#(
  parameter int TAG_W = 3
) (
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0]            way_valid,
  input  logic [TAG_W-1:0]           probe_tag,
  output logic [WAYS-1:0]            match_vec,
  output logic                       any_match,
  output logic                       match_way
);
  // one comparator per way, all evaluated in the same cycle
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_vec[w] = way_valid[w] && (way_tag[w] == probe_tag);
  end

  assign any_match = |match_vec;
  assign match_way = match_vec[1];
endmodule

// File: rtl/wtc_victim.sv
module wtc_victim
  import wtc_pkg::*;
(
  input  logic [WAYS-1:0] way_valid,
  input  logic            lru_way,
  output logic            victim_way
);
  // empty ways are taken first, lowest index first
  always_comb begin
    if (!way_valid[0])      victim_way = 1'b0;
    else if (!way_valid[1]) victim_way = 1'b1;
    else                    victim_way = lru_way;
  end
endmodule

// File: rtl/wtc_store.sv
module wtc_store
  import wtc_pkg::*;
#(
  parameter int SETS   = 2,
  parameter int IDX_W  = 1,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [IDX_W-1:0]                 rd_set,
  output logic [WAYS-1:0][TAG_W-1:0]       rd_tag,
  output logic [WAYS-1:0]                  rd_valid,
  output logic [WAYS-1:0][DATA_W-1:0]      rd_data,
  output logic                             rd_lru,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_set,
  input  logic                             wr_way,
  input  logic [TAG_W-1:0]                 wr_tag,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             touch_en,
  input  logic [IDX_W-1:0]                 touch_set,
  input  logic                             touch_way
);
  logic [SETS-1:0][WAYS-1:0]          valid_q;
  logic [SETS-1:0]                    lru_q;
  logic [WAYS-1:0][TAG_W-1:0]         tag_q  [SETS];
  logic [WAYS-1:0][DATA_W-1:0]        data_q [SETS];

  // control state: reset to empty
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      lru_q   <= '0;
    end else begin
      if (wr_en)    valid_q[wr_set][wr_way] <= 1'b1;
      if (touch_en) lru_q[touch_set]        <= ~touch_way;
    end
  end

  // payload: no reset needed, guarded by valid
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way]  <= wr_tag;
      data_q[wr_set][wr_way] <= wr_data;
    end
  end

  assign rd_tag   = tag_q[rd_set];
  assign rd_data  = data_q[rd_set];
  assign rd_valid = valid_q[rd_set];
  assign rd_lru   = lru_q[rd_set];
endmodule

// File: rtl/wtc_cache_2way.sv
module wtc_cache_2way
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int OFFS_W = 2,
  parameter int SETS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);
  localparam int IDX_W = $clog2(SETS);
  localparam int BLK_W = ADDR_W - OFFS_W;
  localparam int TAG_W = BLK_W - IDX_W;

  ctl_state_e               state_q, state_d;
  logic [BLK_W-1:0]         blk_q;
  logic [DATA_W-1:0]        wdata_q;
  logic                     rsp_valid_q;
  logic [DATA_W-1:0]        rsp_data_q;

  logic                     idle, accept;
  logic [BLK_W-1:0]         look_blk;
  logic [IDX_W-1:0]         look_set;
  logic [TAG_W-1:0]         look_tag;

  logic [WAYS-1:0][TAG_W-1:0]  set_tag;
  logic [WAYS-1:0]             set_valid;
  logic [WAYS-1:0][DATA_W-1:0] set_data;
  logic                        set_lru;

  logic [WAYS-1:0]          hit_vec;
  logic                     hit_any, hit_way, victim_way;

  logic                     wr_en, touch_en, sel_way;
  logic [DATA_W-1:0]        wr_data;

  logic                     unused_offs;
  assign unused_offs = ^req_addr[OFFS_W-1:0];

  assign idle      = (state_q == ST_IDLE);
  assign req_ready = idle;
  assign accept    = req_valid && idle;

  // lookup uses the live request when idle, the held block otherwise
  assign look_blk = idle ? req_addr[ADDR_W-1:OFFS_W] : blk_q;
  assign look_set = look_blk[IDX_W-1:0];
  assign look_tag = look_blk[BLK_W-1:IDX_W];

  wtc_store #(
    .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) store_i (
    .clk(clk), .rst_n(rst_n),
    .rd_set(look_set), .rd_tag(set_tag), .rd_valid(set_valid),
    .rd_data(set_data), .rd_lru(set_lru),
    .wr_en(wr_en), .wr_set(look_set), .wr_way(sel_way),
    .wr_tag(look_tag), .wr_data(wr_data),
    .touch_en(touch_en), .touch_set(look_set), .touch_way(sel_way)
  );

  wtc_tag_match #(.TAG_W(TAG_W)) match_i (
    .way_tag(set_tag), .way_valid(set_valid), .probe_tag(look_tag),
    .match_vec(hit_vec), .any_match(hit_any), .match_way(hit_way)
  );

  wtc_victim victim_i (
    .way_valid(set_valid), .lru_way(set_lru), .victim_way(victim_way)
  );

  always_comb begin
    state_d  = state_q;
    wr_en    = 1'b0;
    touch_en = 1'b0;
    wr_data  = req_wdata;
    sel_way  = hit_any ? hit_way : victim_way;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (req_write) begin
            wr_en    = 1'b1;
            touch_en = 1'b1;
            state_d  = ST_WR_REQ;
          end else if (hit_any) begin
            touch_en = 1'b1;
          end else begin
            state_d  = ST_RD_REQ;
          end
        end
      end
      ST_RD_REQ: if (mem_req_ready) state_d = ST_RD_WAIT;
      ST_RD_WAIT: begin
        sel_way = victim_way;
        wr_data = mem_rsp_rdata;
        if (mem_rsp_valid) begin
          wr_en    = 1'b1;
          touch_en = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      ST_WR_REQ: if (mem_req_ready) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      blk_q       <= '0;
      wdata_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= 1'b0;
      if (accept) begin
        blk_q   <= req_addr[ADDR_W-1:OFFS_W];
        wdata_q <= req_wdata;
      end
      if (accept && !req_write && hit_any) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= set_data[hit_way];
      end
      if (state_q == ST_RD_WAIT && mem_rsp_valid) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= mem_rsp_rdata;
      end
    end
  end

  assign rsp_valid     = rsp_valid_q;
  assign rsp_rdata     = rsp_data_q;
  assign mem_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign mem_req_write = (state_q == ST_WR_REQ);
  assign mem_req_addr  = {blk_q, {OFFS_W{1'b0}}};
  assign mem_req_wdata = wdata_q;
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int OFFS_W = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     req_write,
  input logic [ADDR_W-OFFS_W-1:0] req_blk,
  input logic [DATA_W-1:0]        req_wdata,
  input logic                     rsp_valid,
  input logic                     mem_req_valid,
  input logic                     mem_req_ready,
  input logic                     mem_req_write,
  input logic [ADDR_W-1:0]        mem_req_addr,
  input logic [DATA_W-1:0]        mem_req_wdata,
  input logic [1:0]               hit_vec
);
  logic take;
  assign take = req_valid && req_ready;

  AST_MEM_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[OFFS_W-1:0] == '0); // R1

  AST_HIT_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_write && |hit_vec) |=> (rsp_valid && !mem_req_valid)); // R2

  AST_MISS_FETCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_write && !(|hit_vec)) |=> (mem_req_valid && !mem_req_write)); // R3

  AST_WRITE_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_write) |=> (mem_req_valid && mem_req_write
      && mem_req_addr[ADDR_W-1:OFFS_W] == $past(req_blk)
      && mem_req_wdata == $past(req_wdata))); // R6

  AST_BUSY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready); // R9

  AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write))); // R9

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R11
endmodule

bind wtc_cache_2way wtc_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(OFFS_W)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_blk(req_addr[ADDR_W-1:OFFS_W]), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .hit_vec(hit_vec)
);

// File: tb/wtc_cache_2way_tb_top.sv
module wtc_cache_2way_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, mem_req_valid, mem_req_write;
  logic [31:0] rsp_rdata, mem_req_wdata;
  logic [5:0]  mem_req_addr;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;

  wtc_cache_2way dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int mem_rd_cnt = 0;
  int mem_wr_cnt = 0;
  int cyc = 0;
  int rd_pend = 0;
  logic [3:0]  rd_word = '0;
  logic [31:0] mem_arr [16];
  logic [31:0] exp_mem [16];

  logic [31:0] rd_exp_q [$];
  string       rd_tag_q [$];
  logic [35:0] wr_exp_q [$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: decides at the negedge what the next posedge does
  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 1'b0;
    if (rd_pend > 0) begin
      rd_pend--;
      if (rd_pend == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = mem_arr[rd_word];
      end
    end
    mem_req_ready = (cyc % 3 != 0);
    if (rst_n && mem_req_valid && mem_req_ready) begin
      check(mem_req_addr[1:0] == 2'b00, "R1", "memory address offset",
            32'(mem_req_addr), 32'(mem_req_addr & 6'h3C));
      if (mem_req_write) begin
        mem_wr_cnt++;
        if (wr_exp_q.size() == 0) begin
          check(1'b0, "R6", "unexpected memory write", mem_req_wdata, 32'h0);
        end else begin
          logic [35:0] e;
          e = wr_exp_q.pop_front();
          check(mem_req_addr[5:2] == e[35:32], "R6", "write address",
                32'(mem_req_addr), 32'({e[35:32], 2'b00}));
          check(mem_req_wdata == e[31:0], "R6", "write data",
                mem_req_wdata, e[31:0]);
        end
        mem_arr[mem_req_addr[5:2]] = mem_req_wdata;
      end else begin
        mem_rd_cnt++;
        rd_word = mem_req_addr[5:2];
        rd_pend = 2;
      end
    end
  end

  // scoreboard monitor for load responses
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (rd_exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected response", rsp_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = rd_exp_q.pop_front();
        t = rd_tag_q.pop_front();
        check(rsp_rdata == e, t, "read data", rsp_rdata, e);
      end
    end
  end

  task automatic access(input bit wr, input logic [5:0] a, input logic [31:0] d,
                        input bit exp_hit, input string req);
    int rd0, wr0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    rd0 = mem_rd_cnt;
    wr0 = mem_wr_cnt;
    if (wr) begin
      exp_mem[a[5:2]] = d;
      wr_exp_q.push_back({a[5:2], d});
    end else begin
      rd_exp_q.push_back(exp_mem[a[5:2]]);
      rd_tag_q.push_back(req);
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (!wr)
      check(req_ready == exp_hit, "R9", "ready after load accept",
            32'(req_ready), 32'(exp_hit));
    else
      check(req_ready == 1'b0, "R9", "ready after store accept",
            32'(req_ready), 32'h0);
    while (!(req_ready && rd_exp_q.size() == 0 && wr_exp_q.size() == 0))
      @(negedge clk);
    if (wr)
      check(mem_wr_cnt - wr0 == 1, "R6", "memory writes per store",
            32'(mem_wr_cnt - wr0), 32'h1);
    else
      check(mem_rd_cnt - rd0 == (exp_hit ? 0 : 1), req, "memory reads (hit/miss)",
            32'(mem_rd_cnt - rd0), exp_hit ? 32'h0 : 32'h1);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int w = 0; w < 16; w++) begin
      mem_arr[w] = 32'hC0DE_0000 | (w * 32'h0101);
      exp_mem[w] = mem_arr[w];
    end
    repeat (3) @(negedge clk);
    // R10: reset state at the ports
    check(req_ready == 1'b1, "R10", "req_ready in reset", 32'(req_ready), 32'h1);
    check(rsp_valid == 1'b0, "R10", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
    check(mem_req_valid == 1'b0, "R10", "mem_req_valid in reset",
          32'(mem_req_valid), 32'h0);
    rst_n = 1'b1;

    access(0, 6'h00, 0, 0, "R10");  // cold miss, fills set0 way0 (R3)
    access(0, 6'h02, 0, 1, "R1");   // other offset of same block hits
    access(0, 6'h08, 0, 0, "R5");   // empty way1 chosen
    access(0, 6'h00, 0, 1, "R4");
    access(0, 6'h08, 0, 1, "R4");
    access(0, 6'h04, 0, 0, "R3");   // set1 way0
    access(0, 6'h0C, 0, 0, "R3");   // set1 way1
    access(0, 6'h00, 0, 1, "R4");   // all four resident together
    access(0, 6'h08, 0, 1, "R2");   // set0 victim now way0 (0x00)
    access(0, 6'h10, 0, 0, "R5");   // evicts 0x00
    access(0, 6'h08, 0, 1, "R5");   // survivor still hits
    access(0, 6'h00, 0, 0, "R5");   // evicted block misses
    access(0, 6'h04, 0, 1, "R2");   // set1: victim becomes way1
    access(1, 6'h0C, 32'h1111_AAAA, 1, "R7");
    access(0, 6'h04, 0, 1, "R11");  // write hit made no second copy
    access(0, 6'h0C, 0, 1, "R7");   // new data, victim now way0 (0x04)
    access(1, 6'h14, 32'h2222_BBBB, 0, "R8");
    access(0, 6'h14, 0, 1, "R8");
    access(0, 6'h0C, 0, 1, "R8");
    access(0, 6'h04, 0, 0, "R8");   // replaced by the write allocation
    access(1, 6'h1D, 32'h3333_CCCC, 0, "R1");
    access(0, 6'h1C, 0, 1, "R1");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule